// File: doc/BRIEF.md
# Processor Reset and Watchdog Supervisor

This block keeps a processor in reset while its supply is unhealthy and while its software appears to be stuck. A comparator elsewhere on the chip reports supply health as a single flag. The processor proves it is alive by flipping a service line. The service line arrives as a two-bit code, so a pad resolver can report a mid-level or undriven line. That code switches the watchdog off.

Every reset cause is stretched. The reset outputs stay asserted for a fixed number of prescaler ticks after the cause goes away. If servicing stops, the block issues a stretched reset pulse once per timeout period, and this continues for as long as the line stays still. A separate active-low watchdog status output records that a timeout has happened. It clears on the next service edge, when the watchdog is disabled, or when the supply is faulty.

All timing counts in ticks of a one-cycle enable from an external prescaler. The defaults are `HOLD_TICKS`=140 and `WD_TICKS`=1600, which give 140 ms and 1.6 s with a 1 ms tick. The two asynchronous inputs each pass through a two-flop synchronizer.

Top module: `proc_supervisor`

## Requirements
- R1: While the synchronized supply flag is low, `rst_out_n` is 0. The flag reaches the reset logic two clock cycles after the input changes.
- R2: After the synchronized supply flag returns high, reset stays asserted for exactly `HOLD_TICKS` ticks. With a tick on every cycle, `rst_out_n` rises `HOLD_TICKS`+2 cycles after `supply_ok` rises.
- R3: `svc_code` is encoded as 2'b00 for low, 2'b01 for high, and 2'b1x for mid-level or floating. Any low-to-high or high-to-low change between the two valid codes restarts the watchdog count. An edge spacing of up to `WD_TICKS` ticks therefore never causes a reset.
- R4: If a valid service code holds steady, reset asserts once `WD_TICKS` ticks have elapsed since the last edge, or since the count last started. Measured from the driven input, this is `WD_TICKS`+3 cycles after a toggle and `WD_TICKS`+2 cycles after leaving the mid code, since leaving mid is not an edge.
- R5: A watchdog reset lasts exactly `HOLD_TICKS` ticks. The watchdog count is held clear while reset is asserted. A steady line therefore gives a train of `HOLD_TICKS` low and `WD_TICKS` high, repeating.
- R6: While the synchronized code is mid-level, no watchdog reset occurs and `wdo_n` is 1.
- R7: `wdo_n` falls in the same cycle as a watchdog-caused reset. It returns to 1 three cycles after the next service-code toggle is driven.
- R8: `wdo_n` is forced to 1 while the synchronized supply flag is low, three cycles after `supply_ok` falls.
- R9: `rst_out` is always the exact complement of `rst_out_n`.
- R10: The hold and watchdog counts advance only in cycles where `tick` is 1. Reset stays asserted indefinitely while `tick` is 0.
- R11: While `rst_n` is low, reset is asserted and `wdo_n` is 1. After `rst_n` is released with a healthy supply, `rst_out_n` rises `HOLD_TICKS`+2 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick | input | 1 | One-cycle time-base enable from the prescaler |
| supply_ok | input | 1 | Comparator flag, 1 when supply is above the trip level (asynchronous) |
| svc_code | input | 2 | Encoded service line: 00 low, 01 high, 1x mid/floating (asynchronous) |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset, complement of `rst_out_n` |
| wdo_n | output | 1 | Active-low watchdog timeout status |

## Verification
Supply dips of three to eight cycles are swept. This shows that the release delay depends only on when the supply returns, not on how long the dip lasted. The service line is toggled at every spacing from one tick up to `WD_TICKS` and then at `WD_TICKS`+1. This separates the last safe spacing from the first spacing that starves the watchdog. A long mid-level hold is compared with a steady valid level to tell the disabled timer from a running one. The timeout latency after a toggle is compared with the latency after leaving mid, which shows that leaving the mid code is not counted as an edge. The steady-level pulse train, tick stalls and supply faults during a watchdog reset each test a separate path into the hold counter and the status flag.

// File: rtl/sup_pkg.sv
// Package: shared encodings and helpers for the reset/watchdog supervisor.
// Assumes the pad resolver delivers a two-bit code; bit 1 set means mid-level.
package sup_pkg;

    typedef enum logic [1:0] {
        SVC_LOW   = 2'b00,
        SVC_HIGH  = 2'b01,
        SVC_MID   = 2'b10,
        SVC_FLOAT = 2'b11
    } svc_code_e;

    // True when the code is one of the two driven logic levels.
    function automatic logic svc_is_valid(input logic [1:0] code);
        return !code[1];
    endfunction

endpackage

// File: rtl/sup_sync.sv
// Module: multi-stage synchronizer for asynchronous control inputs.
// Assumes inputs change slowly compared to clk; all stages reset to INIT.
module sup_sync #(
    parameter int               WIDTH  = 1,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the input through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/svc_edge.sv
// Module: service-line edge detector for the three-level watchdog input.
// Assumes a synchronized code. An edge counts only between the two valid
// levels; entering or leaving the mid-level code never counts as an edge.
module svc_edge
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    output logic       wd_en,
    output logic       svc_toggle
);

    logic last_lvl;
    logic last_vld;

    assign wd_en      = svc_is_valid(code);
    assign svc_toggle = wd_en && last_vld && (last_lvl != code[0]);

    // Remember the last valid level; a mid code forgets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lvl <= 1'b0;
            last_vld <= 1'b0;
        end else if (wd_en) begin
            last_lvl <= code[0];
            last_vld <= 1'b1;
        end else begin
            last_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/wd_counter.sv
// Module: watchdog tick counter. It pulses expire for one cycle when
// WD_TICKS ticks pass with no restart. It is cleared while disabled, while
// reset is held, or on a service edge; the edge has priority over expiry.
module wd_counter #(
    parameter int WD_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enabled,
    input  logic restart,
    input  logic hold,
    output logic expire
);

    localparam int            CW   = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

    logic [CW-1:0] cnt;

    assign expire = enabled && !hold && !restart && tick && (cnt == LAST);

    // Count ticks since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || !enabled || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rst_hold.sv
// Module: reset stretcher. Any cause cycle reloads HOLD_TICKS; the count
// falls by one on each tick once the cause has gone. Reset is active while
// the count is nonzero. It is loaded at system reset.
module rst_hold #(
    parameter int HOLD_TICKS = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic active
);

    localparam int            HW   = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);

    logic [HW-1:0] hcnt;

    // Reload on a cause, else drain on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= FULL;
        end else if (cause) begin
            hcnt <= FULL;
        end else if (tick && hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
        end
    end

    assign active = (hcnt != '0);

endmodule

// File: rtl/proc_supervisor.sv
// Module: processor reset and watchdog supervisor (top).
// Synchronizes the supply flag and the service code, stretches every reset
// cause to HOLD_TICKS ticks, and runs a watchdog of WD_TICKS ticks that the
// mid-level code disables. Assumes tick is a single-cycle enable.
module proc_supervisor
    import sup_pkg::*;
#(
    parameter int HOLD_TICKS  = 140,
    parameter int WD_TICKS    = 1600,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic [1:0] svc_code,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic       wdo_n
);

    logic       supply_s;
    logic [1:0] code_s;
    logic       wd_en;
    logic       svc_toggle;
    logic       wd_expire;
    logic       rst_active;

    sup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sup (
        .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s)
    );

    sup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(SVC_MID)) u_sync_svc (
        .clk(clk), .rst_n(rst_n), .d(svc_code), .q(code_s)
    );

    svc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .code(code_s),
        .wd_en(wd_en), .svc_toggle(svc_toggle)
    );

    wd_counter #(.WD_TICKS(WD_TICKS)) u_wd (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enabled(wd_en),
        .restart(svc_toggle), .hold(rst_active), .expire(wd_expire)
    );

    rst_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cause(!supply_s || wd_expire), .active(rst_active)
    );

    // Watchdog status: low after expiry, cleared by edge, disable or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdo_n <= 1'b1;
        end else if (!supply_s || !wd_en || svc_toggle) begin
            wdo_n <= 1'b1;
        end else if (wd_expire) begin
            wdo_n <= 1'b0;
        end
    end

    assign rst_out_n = !rst_active;
    assign rst_out   = rst_active;

endmodule

// File: rtl/proc_supervisor_chk.sv
// Module: property checker for proc_supervisor, attached by bind below.
// Observes ports only; keeps one tick counter to check the hold window.
module proc_supervisor_chk #(
    parameter int HOLD_TICKS = 140
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       supply_ok,
    input logic [1:0] svc_code,
    input logic       rst_out_n,
    input logic       wdo_n
);

    int low_ticks;

    // Count ticks seen while reset is asserted, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_out_n) begin
            low_ticks <= 0;
        end else if (tick && low_ticks < HOLD_TICKS + 1) begin
            low_ticks <= low_ticks + 1;
        end
    end

    AST_FAULT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok, 3) |-> !rst_out_n); // R1

    AST_FAULT_CLEARS_WDO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok, 3) |-> wdo_n); // R8

    AST_MID_KEEPS_WDO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(svc_code[1], 3) |-> wdo_n); // R6

    AST_WDO_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> $fell(rst_out_n)); // R7

    AST_HOLD_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (low_ticks >= HOLD_TICKS)); // R2

endmodule

bind proc_supervisor proc_supervisor_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .svc_code(svc_code), .rst_out_n(rst_out_n), .wdo_n(wdo_n)
);

// File: tb/proc_supervisor_bench.sv
// Bench: sweeps supply dips and service spacings on a small configuration;
// expected latencies are derived from the tick counts and sync depth.
module proc_supervisor_bench;

    localparam int HOLD = 5;
    localparam int WD   = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       supply_ok;
    logic [1:0] svc_code;
    logic       rst_out_n;
    logic       rst_out;
    logic       wdo_n;

    int checks  = 0;
    int fails   = 0;
    int cmp_cnt = 0;
    int cmp_bad = 0;

    always #5 clk = ~clk;

    proc_supervisor #(.HOLD_TICKS(HOLD), .WD_TICKS(WD)) u_proc_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .svc_code(svc_code), .rst_out_n(rst_out_n), .rst_out(rst_out),
        .wdo_n(wdo_n)
    );

    // R9: compare the two reset outputs on every sample.
    always @(negedge clk) begin
        cmp_cnt++;
        if (rst_out !== ~rst_out_n) cmp_bad++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_rst(input logic want, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_out_n !== want && n < 4 * (HOLD + WD));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int n;
        int bad;
        rst_n     = 1'b0;
        tick      = 1'b1;
        supply_ok = 1'b1;
        svc_code  = 2'b10;
        cycles(4);
        check("R11 reset state rst_out_n", rst_out_n, 0);
        check("R11 reset state wdo_n", wdo_n, 1);
        rst_n = 1'b1;
        wait_rst(1'b1, n);
        check("R11 power-on release delay", n, HOLD + 2);

        // R1 R2 R8: sweep supply dip lengths
        for (int d = 3; d <= 8; d++) begin
            supply_ok = 1'b0;
            cycles(d);
            check("R1 reset during dip", rst_out_n, 0);
            check("R8 wdo_n during dip", wdo_n, 1);
            supply_ok = 1'b1;
            wait_rst(1'b1, n);
            check("R2 release after dip", n, HOLD + 2);
        end

        // R6: mid-level disables the watchdog
        bad = 0;
        repeat (3 * WD) begin
            @(negedge clk);
            if (!rst_out_n || !wdo_n) bad++;
        end
        check("R6 mid-level quiet samples", bad, 0);

        // R4 R7: leaving mid is not an edge; steady low starves watchdog
        svc_code = 2'b00;
        wait_rst(1'b0, n);
        check("R4 timeout after mid exit", n, WD + 2);
        check("R7 wdo_n low on timeout", wdo_n, 0);

        // R5: repeating pulse train
        for (int k = 0; k < 3; k++) begin
            wait_rst(1'b1, n);
            check("R5 pulse low length", n, HOLD);
            wait_rst(1'b0, n);
            check("R5 pulse spacing", n, WD);
            check("R7 wdo_n stays low in train", wdo_n, 0);
        end

        // R7: next edge clears the status
        wait_rst(1'b1, n);
        svc_code = 2'b01;
        cycles(2);
        check("R7 wdo_n before edge lands", wdo_n, 0);
        cycles(1);
        check("R7 wdo_n after edge", wdo_n, 1);

        // R3: every spacing up to WD keeps reset away
        bad = 0;
        for (int per = 1; per <= WD; per++) begin
            repeat (3) begin
                svc_code[0] = ~svc_code[0];
                for (int j = 0; j < per; j++) begin
                    @(negedge clk);
                    if (!rst_out_n) bad++;
                end
            end
        end
        check("R3 serviced spacings 1..WD", bad, 0);

        // R4: spacing WD+1 times out, measured from a toggle
        svc_code[0] = ~svc_code[0];
        wait_rst(1'b0, n);
        check("R4 timeout after toggle", n, WD + 3);
        check("R7 wdo_n low after toggle timeout", wdo_n, 0);

        // R8: supply fault forces status high
        supply_ok = 1'b0;
        cycles(3);
        check("R8 wdo_n forced by fault", wdo_n, 1);
        check("R1 reset on fault", rst_out_n, 0);

        // R10: counts freeze without tick
        tick = 1'b0;
        supply_ok = 1'b1;
        cycles(30);
        check("R10 reset held with no tick", rst_out_n, 0);
        tick = 1'b1;
        wait_rst(1'b1, n);
        check("R10 release after ticks resume", n, HOLD);

        svc_code = 2'b10;
        cycles(3);
        check("R9 complement mismatches", cmp_bad, 0);
        check("R9 samples taken", (cmp_cnt > 0) ? 1 : 0, 1);
        finish_run();
    end

endmodule